// File: doc/BRIEF.md
# Packet Loopback Endpoint Handler

This block sits on the user side of a byte-wide synchronous packet port driven by a USB protocol engine. The engine signals a transaction with an active strobe, names the endpoint on a 3-bit number, and moves one byte per clock when it raises its next strobe. The handler takes OUT payloads aimed at one configured sink endpoint into a two-bank ping-pong store. It later hands those payloads back, oldest first, as IN payloads on a configured source endpoint.

When a packet arrives, the handler drops the two CRC16 bytes that close it. It throws away any packet that the engine flags as corrupt when the transaction ends. A transmitted packet stays in its bank until the host takes it cleanly, so the same packet can be sent again after a failed delivery. The handler answers with ready for a transaction it can serve and holds ready low for any other transaction, so the engine NAKs it. It raises stall only against a receive that runs past the bulk maximum.

Top module: `usbpkt_loopback`

## Requirements
- R1: After the engine raises pkt_active, pkt_ready is high on the next clock when the endpoint is the sink and a bank is free, or when it is the source and a bank holds a packet.
- R2: A transaction on any other endpoint, on the sink with both banks full, or on the source with no packet stored keeps pkt_ready low for its whole duration.
- R3: While receiving, exactly one byte is taken on each clock where pkt_next is high. The last two bytes taken are CRC and are not stored, so the stored length is the byte count minus two.
- R4: A receive whose pkt_active falls while pkt_err is high is discarded, and its bank stays free.
- R5: On transmit, tx_data holds the first stored byte when pkt_ready rises. After each clock with pkt_next high, tx_data holds the following byte one clock later.
- R6: On transmit, pkt_ready drops on the clock after the clock that takes the last stored byte.
- R7: A transmit whose pkt_active falls while pkt_err is high keeps its bank. The next source transaction sends the same bytes again, starting from the first.
- R8: A receive of only the two CRC bytes stores a zero-length packet. The matching transmit raises pkt_ready, keeps it high with no bytes until pkt_active falls, and then frees the bank.
- R9: Stored packets go out in the order they arrived, alternating between the two banks.
- R10: A receive of more than MAX_BYTES+2 bytes raises pkt_stall on the clock after the excess byte is taken. pkt_stall stays high until pkt_active falls, and the packet is discarded.
- R11: After reset, pkt_ready and pkt_stall are low and both banks are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_active | input | 1 | Transaction in progress |
| pkt_next | input | 1 | Byte transfer strobe |
| pkt_err | input | 1 | Transfer failed, sampled on the clock where pkt_active falls |
| pkt_ep | input | 3 | Endpoint number, valid while pkt_active is high |
| rx_data | input | 8 | Received byte |
| pkt_ready | output | 1 | Transaction accepted (low means NAK) |
| pkt_stall | output | 1 | Stall request for an oversize receive |
| tx_data | output | 8 | Byte to transmit |

## Verification
Receives use payloads of 5, 7, 0 and 512 bytes, with gaps in pkt_next, so a byte is shown to be taken only on a strobe clock and the CRC stripping is tested at both size extremes. Transmits use both a continuous pkt_next and a pkt_next with gaps. Comparing the returned bytes and the clock where pkt_ready drops against the sent payload confirms the stored length and the bank order. A corrupt receive, a failed transmit, refused endpoints, a full store, an empty store and an oversize packet each produce a different state afterwards: a free bank, a replayed packet, or a NAK. Each of these is read back through a later transaction.

// File: rtl/usbpkt_lb_pkg.sv
package usbpkt_lb_pkg;

    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_SINK   = 2'd1,
        XF_SOURCE = 2'd2,
        XF_REFUSE = 2'd3
    } xfer_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic take;
    } port_strobe_t;

    localparam int BANKS = 2;
    localparam int CRC_BYTES = 2;

    function automatic logic other_bank(input logic b);
        return ~b;
    endfunction

endpackage

// File: rtl/usbpkt_lb_strobe.sv
module usbpkt_lb_strobe
    import usbpkt_lb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         next,
    output port_strobe_t stb
);
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active;
    end

    always_comb begin
        stb.rise = active & ~active_q;
        stb.fall = ~active & active_q;
        stb.take = active & next;
    end
endmodule

// File: rtl/usbpkt_lb_bufctl.sv
module usbpkt_lb_bufctl
    import usbpkt_lb_pkg::*;
#(
    parameter  int MAX_BYTES = 512,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_commit,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             tx_release,
    output logic             free_avail,
    output logic             data_avail,
    output logic [LEN_W-1:0] src_len,
    output logic             wr_bank,
    output logic             rd_bank
);
    logic [BANKS-1:0] full_q;
    logic [LEN_W-1:0] len_q [BANKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q  <= '0;
            wr_bank <= 1'b0;
            rd_bank <= 1'b0;
        end else begin
            if (rx_commit) begin
                full_q[wr_bank] <= 1'b1;
                wr_bank         <= other_bank(wr_bank);
            end
            if (tx_release) begin
                full_q[rd_bank] <= 1'b0;
                rd_bank         <= other_bank(rd_bank);
            end
        end
    end

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_len
            always_ff @(posedge clk) begin
                if (rst)
                    len_q[b] <= '0;
                else if (rx_commit && (wr_bank == b[0]))
                    len_q[b] <= rx_len;
            end
        end
    endgenerate

    assign free_avail = ~full_q[wr_bank];
    assign data_avail = full_q[rd_bank];
    assign src_len    = len_q[rd_bank];
endmodule

// File: rtl/usbpkt_lb_store.sv
module usbpkt_lb_store #(
    parameter  int MAX_BYTES = 512,
    localparam int IDX_W     = $clog2(MAX_BYTES),
    localparam int DEPTH     = 2 * MAX_BYTES
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[{wr_bank, wr_idx}] <= wr_data;
        rd_data <= mem[{rd_bank, rd_idx}];
    end
endmodule

// File: rtl/usbpkt_lb_fsm.sv
module usbpkt_lb_fsm
    import usbpkt_lb_pkg::*;
#(
    parameter  int SINK_EP   = 1,
    parameter  int SOURCE_EP = 4,
    parameter  int MAX_BYTES = 512,
    localparam int IDX_W     = $clog2(MAX_BYTES),
    localparam int CNT_W     = $clog2(MAX_BYTES + CRC_BYTES + 1),
    localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  port_strobe_t     stb,
    input  logic             err,
    input  logic [2:0]       ep,
    input  logic             free_avail,
    input  logic             data_avail,
    input  logic [LEN_W-1:0] src_len,
    output logic             ready,
    output logic             stall,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             rx_commit,
    output logic [LEN_W-1:0] rx_len,
    output logic             tx_release
);
    localparam logic [CNT_W-1:0] CNT_PAYLOAD = CNT_W'(MAX_BYTES);
    localparam logic [CNT_W-1:0] CNT_LIMIT   = CNT_W'(MAX_BYTES + CRC_BYTES);
    localparam logic [CNT_W-1:0] CNT_CRC     = CNT_W'(CRC_BYTES);
    localparam logic [2:0]       EP_SINK     = 3'(SINK_EP);
    localparam logic [2:0]       EP_SOURCE   = 3'(SOURCE_EP);

    xfer_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             last_tx;

    assign cnt_inc = cnt_q + CNT_W'(1);
    assign last_tx = (cnt_inc == CNT_W'(src_len));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XF_IDLE;
            ready   <= 1'b0;
            stall   <= 1'b0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            unique case (state_q)
                XF_IDLE: begin
                    if (stb.rise) begin
                        cnt_q  <= '0;
                        done_q <= 1'b0;
                        if (ep == EP_SINK && free_avail) begin
                            state_q <= XF_SINK;
                            ready   <= 1'b1;
                        end else if (ep == EP_SOURCE && data_avail) begin
                            state_q <= XF_SOURCE;
                            ready   <= 1'b1;
                        end else begin
                            state_q <= XF_REFUSE;
                        end
                    end
                end
                XF_SINK: begin
                    if (stb.fall) begin
                        state_q <= XF_IDLE;
                        ready   <= 1'b0;
                        stall   <= 1'b0;
                    end else if (stb.take) begin
                        if (cnt_q == CNT_LIMIT) stall <= 1'b1;
                        else                    cnt_q <= cnt_inc;
                    end
                end
                XF_SOURCE: begin
                    if (stb.fall) begin
                        state_q <= XF_IDLE;
                        ready   <= 1'b0;
                    end else if (stb.take && !done_q) begin
                        cnt_q <= cnt_inc;
                        if (last_tx) begin
                            done_q <= 1'b1;
                            ready  <= 1'b0;
                        end
                    end
                end
                XF_REFUSE: begin
                    if (stb.fall) state_q <= XF_IDLE;
                end
                default: state_q <= XF_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en  = (state_q == XF_SINK) && stb.take && (cnt_q < CNT_PAYLOAD);
        wr_idx = cnt_q[IDX_W-1:0];
        if (state_q == XF_SOURCE && stb.take && !done_q)
            rd_idx = cnt_inc[IDX_W-1:0];
        else if (state_q == XF_SOURCE)
            rd_idx = cnt_q[IDX_W-1:0];
        else
            rd_idx = '0;
        rx_commit  = (state_q == XF_SINK) && stb.fall && !err && !stall && (cnt_q >= CNT_CRC);
        rx_len     = LEN_W'(cnt_q - CNT_CRC);
        tx_release = (state_q == XF_SOURCE) && stb.fall && !err;
    end
endmodule

// File: rtl/usbpkt_loopback.sv
module usbpkt_loopback
    import usbpkt_lb_pkg::*;
#(
    parameter int SINK_EP   = 1,
    parameter int SOURCE_EP = 4,
    parameter int MAX_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pkt_active,
    input  logic       pkt_next,
    input  logic       pkt_err,
    input  logic [2:0] pkt_ep,
    input  logic [7:0] rx_data,
    output logic       pkt_ready,
    output logic       pkt_stall,
    output logic [7:0] tx_data
);
    localparam int IDX_W = $clog2(MAX_BYTES);
    localparam int LEN_W = $clog2(MAX_BYTES + 1);

    port_strobe_t     stb;
    logic             free_avail, data_avail;
    logic [LEN_W-1:0] src_len, rx_len;
    logic             wr_bank, rd_bank;
    logic             wr_en, rx_commit, tx_release;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    usbpkt_lb_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .active (pkt_active),
        .next   (pkt_next),
        .stb    (stb)
    );

    usbpkt_lb_fsm #(
        .SINK_EP   (SINK_EP),
        .SOURCE_EP (SOURCE_EP),
        .MAX_BYTES (MAX_BYTES)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .stb        (stb),
        .err        (pkt_err),
        .ep         (pkt_ep),
        .free_avail (free_avail),
        .data_avail (data_avail),
        .src_len    (src_len),
        .ready      (pkt_ready),
        .stall      (pkt_stall),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .rd_idx     (rd_idx),
        .rx_commit  (rx_commit),
        .rx_len     (rx_len),
        .tx_release (tx_release)
    );

    usbpkt_lb_bufctl #(.MAX_BYTES(MAX_BYTES)) u_bufctl (
        .clk        (clk),
        .rst        (rst),
        .rx_commit  (rx_commit),
        .rx_len     (rx_len),
        .tx_release (tx_release),
        .free_avail (free_avail),
        .data_avail (data_avail),
        .src_len    (src_len),
        .wr_bank    (wr_bank),
        .rd_bank    (rd_bank)
    );

    usbpkt_lb_store #(.MAX_BYTES(MAX_BYTES)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (rx_data),
        .rd_bank (rd_bank),
        .rd_idx  (rd_idx),
        .rd_data (tx_data)
    );
endmodule

// File: rtl/usbpkt_loopback_chk.sv
module usbpkt_loopback_chk (
    input logic clk,
    input logic rst,
    input logic active,
    input logic next,
    input logic ready,
    input logic stall,
    input logic rx_commit,
    input logic tx_release
);
    // R2
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !$past(active)) |-> !ready);

    // R1
    ready_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(active));

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(ready) && active) |-> $past(next));

    // R10
    stall_window_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> $past(active));

    // R10
    stall_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stall) |-> !active);

    // R4
    commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_commit || tx_release) |-> ($past(active) && !active));
endmodule

bind usbpkt_loopback usbpkt_loopback_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .active     (pkt_active),
    .next       (pkt_next),
    .ready      (pkt_ready),
    .stall      (pkt_stall),
    .rx_commit  (rx_commit),
    .tx_release (tx_release)
);

// File: tb/usbpkt_loopback_bench.sv
module usbpkt_loopback_bench;
    localparam int MAXB = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       active = 1'b0;
    logic       next = 1'b0;
    logic       err = 1'b0;
    logic [2:0] ep = 3'd0;
    logic [7:0] rx_byte = 8'd0;
    logic       ready, stall;
    logic [7:0] tx_byte;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    usbpkt_loopback u_usbpkt_loopback (
        .clk        (clk),
        .rst        (rst),
        .pkt_active (active),
        .pkt_next   (next),
        .pkt_err    (err),
        .pkt_ep     (ep),
        .rx_data    (rx_byte),
        .pkt_ready  (ready),
        .pkt_stall  (stall),
        .tx_data    (tx_byte)
    );

    typedef struct packed {
        logic       is_tx;
        logic [2:0] ep;
        logic [9:0] len;
        logic [7:0] seed;
        logic       err;
        logic       rdy;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd1, 10'd5,   8'd1, 1'b0, 1'b1},  // R3 store bank A
        '{1'b0, 3'd1, 10'd3,   8'd2, 1'b1, 1'b1},  // R4 corrupt, dropped
        '{1'b0, 3'd1, 10'd7,   8'd3, 1'b0, 1'b1},  // R9 store bank B
        '{1'b0, 3'd1, 10'd4,   8'd4, 1'b0, 1'b0},  // R2 both full
        '{1'b1, 3'd4, 10'd5,   8'd1, 1'b1, 1'b1},  // R7 failed delivery
        '{1'b1, 3'd4, 10'd5,   8'd1, 1'b0, 1'b1},  // R7 replay
        '{1'b0, 3'd2, 10'd2,   8'd5, 1'b0, 1'b0},  // R2 other endpoint
        '{1'b1, 3'd4, 10'd7,   8'd3, 1'b0, 1'b1},  // R9 second packet
        '{1'b1, 3'd4, 10'd0,   8'd0, 1'b0, 1'b0},  // R2 empty store
        '{1'b0, 3'd1, 10'd0,   8'd6, 1'b0, 1'b1},  // R8 zero length
        '{1'b1, 3'd4, 10'd0,   8'd6, 1'b0, 1'b1},  // R8 zero length out
        '{1'b0, 3'd1, 10'd512, 8'd7, 1'b0, 1'b1},  // R3 bulk maximum
        '{1'b1, 3'd4, 10'd512, 8'd7, 1'b0, 1'b1}   // R5 bulk maximum out
    };

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37) + (i * 11) + (i >> 4));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic refused();
        repeat (3) begin
            @(negedge clk);
            chk(ready == 1'b0, "R2 ready held low", int'(ready), 0);
        end
        active = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_rx(input logic [2:0] e, input int len, input int seed,
                         input logic bad, input logic exp_rdy);
        @(negedge clk);
        ep = e;
        active = 1'b1;
        @(negedge clk);
        chk(ready == exp_rdy, "R1 ready after start (rx)", int'(ready), int'(exp_rdy));
        if (!exp_rdy) begin
            refused();
            return;
        end
        for (int i = 0; i < len + 2; i++) begin
            if (i % 5 == 4) begin
                next = 1'b0;
                rx_byte = 8'hEE;   // R3 not taken: next low
                @(negedge clk);
            end
            next = 1'b1;
            rx_byte = (i < len) ? pat(seed, i) : ((i == len) ? 8'hC5 : 8'h3A);
            @(negedge clk);
        end
        next = 1'b0;
        active = 1'b0;
        err = bad;
        @(negedge clk);
        err = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_tx(input logic [2:0] e, input int len, input int seed,
                         input logic bad, input logic exp_rdy);
        @(negedge clk);
        ep = e;
        active = 1'b1;
        @(negedge clk);
        chk(ready == exp_rdy, "R1 ready after start (tx)", int'(ready), int'(exp_rdy));
        if (!exp_rdy) begin
            refused();
            return;
        end
        if (len > 0)
            chk(tx_byte == pat(seed, 0), "R5 first byte", int'(tx_byte), int'(pat(seed, 0)));
        for (int i = 0; i < len; i++) begin
            if (i % 3 == 2) begin
                next = 1'b0;
                @(negedge clk);
                chk(tx_byte == pat(seed, i), "R5 byte held without next",
                    int'(tx_byte), int'(pat(seed, i)));
            end
            next = 1'b1;
            @(negedge clk);
            if (i + 1 < len) begin
                chk(tx_byte == pat(seed, i + 1), "R3 R5 stored byte",
                    int'(tx_byte), int'(pat(seed, i + 1)));
                chk(ready == 1'b1, "R6 ready kept before last byte", int'(ready), 1);
            end else begin
                chk(ready == 1'b0, "R6 R3 ready drop after last byte", int'(ready), 0);
            end
        end
        next = 1'b0;
        if (len == 0) begin
            repeat (2) @(negedge clk);
            chk(ready == 1'b1, "R8 zero-length ready held", int'(ready), 1);
        end
        active = 1'b0;
        err = bad;
        @(negedge clk);
        err = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(ready == 1'b0, "R11 ready after reset", int'(ready), 0);
        chk(stall == 1'b0, "R11 stall after reset", int'(stall), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1'b0, "R11 ready idle", int'(ready), 0);
        // R11 empty store: source refused
        do_tx(3'd4, 0, 0, 1'b0, 1'b0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].is_tx)
                do_tx(VECS[v].ep, int'(VECS[v].len), int'(VECS[v].seed), VECS[v].err, VECS[v].rdy);
            else
                do_rx(VECS[v].ep, int'(VECS[v].len), int'(VECS[v].seed), VECS[v].err, VECS[v].rdy);
        end

        // R10 oversize receive
        @(negedge clk);
        ep = 3'd1;
        active = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R10 oversize rx accepted", int'(ready), 1);
        for (int i = 0; i < MAXB + 3; i++) begin
            next = 1'b1;
            rx_byte = pat(9, i);
            @(negedge clk);
            if (i == MAXB + 1)
                chk(stall == 1'b0, "R10 no stall at limit", int'(stall), 0);
        end
        chk(stall == 1'b1, "R10 stall after excess byte", int'(stall), 1);
        next = 1'b0;
        @(negedge clk);
        chk(stall == 1'b1, "R10 stall held while active", int'(stall), 1);
        active = 1'b0;
        @(negedge clk);
        chk(stall == 1'b0, "R10 stall released", int'(stall), 0);
        // R10 oversize packet discarded: nothing to send
        do_tx(3'd4, 0, 0, 1'b0, 1'b0);
        // R4 bank still usable after discard
        do_rx(3'd1, 4, 11, 1'b0, 1'b1);
        do_tx(3'd4, 4, 11, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule